// File: doc/BRIEF.md
# Synchronous Stop Gate for Divided PCI-Rate Clocks

This block drives a group of slow clock outputs from one fast reference clock. The slow clocks are not synthesized here. A shared counter produces a 33 MHz-class source waveform and a source at twice that rate, both as levels in the fast domain. Each output is a registered copy of one source, ANDed with a per-output run flag. The run flag can change only at a phase boundary of the source it follows. This is how every output starts and stops without a shortened pulse.

An active-low stop request passes through a two-flop synchronizer. It then halts every output that is running at the slow rate and is not marked free-running. Outputs switched to the double rate, outputs with their free-running bit set and the dedicated always-on output all ignore the request. Each output also has an enable bit, and clearing it holds that output low. The enable bit goes through the same boundary-aligned gating as the stop request.

Top module: `pclk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every output (`pclk_o` and `fixed_clk_o`) is low.
- R2: With `HALF33` = H, the slow source has a period of 2H fast cycles. After the k-th rising fast edge following reset release (k = 1, 2, ...), it is high when (k-1) mod 2H < H. The double-rate source is high when (k-1) mod H < H/2. An enabled output that is not stopped reproduces its selected source exactly.
- R3: An output falls only when its source falls. A stop or disable never cuts a high phase short: every high pulse is H fast cycles long (H/2 at the double rate).
- R4: An output rises only when its source rises. After a stop or disable is released, the output waits for the next source rising edge, so its first high pulse has full width.
- R5: `stop_n_i` (0 = stop) is captured by two flops. A level sampled at fast edge a decides the run state at source rising boundaries reached at edge a+2 or later.
- R6: `fixed_clk_o` always follows the slow source while `fixed_en_i` is 1, whatever `stop_n_i` is.
- R7: An output whose `fast_sel_i` bit is 1 follows the double-rate source and ignores `stop_n_i`. `fast_sel_i` is static configuration and is changed only during reset.
- R8: An output whose `free_run_i` bit is 1 ignores `stop_n_i`.
- R9: An output whose enable bit (`pclk_en_i` or `fixed_en_i`) is 0 is held off from its next source rising boundary on. After one full slow period with the bit at 0, it is low.
- R10: A stopped or disabled output is held low, never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_n_i | input | 1 | Asynchronous active-low stop request |
| pclk_en_i | input | NUM_PCLK | Per-output enable, 1 = enabled |
| free_run_i | input | NUM_PCLK | Per-output free-running override, 1 = ignore stop |
| fast_sel_i | input | NUM_PCLK | Per-output rate select, 1 = double rate |
| fixed_en_i | input | 1 | Enable for the dedicated always-on output |
| pclk_o | output | NUM_PCLK | Gated clock outputs |
| fixed_clk_o | output | 1 | Dedicated output, never stopped |

## Verification
The first pattern is directed. The stop request is asserted in the middle of a high phase and released in the middle of a low phase. This separates gating at boundaries from gating at once, because any immediate gating shows up as a short pulse or a late first edge. Runs with some outputs free-running, some at the double rate and some disabled check that the exemptions apply per output and do not leak between outputs. Long random stretches toggle the stop request near every phase offset. These catch a wrong synchronizer depth or a wrong boundary choice, since both shift the first or last pulse by a cycle. Two reset segments with different rate masks check the per-output rate mux.

// File: rtl/pcg_pkg.sv
// Shared types for the clock stop gate.
// A source bundle carries the level of a divided clock in the current fast
// cycle and a look-ahead of the next cycle, so gating can be registered.
package pcg_pkg;

    typedef struct packed {
        logic lvl_cur;   // source level in this fast cycle
        logic lvl_nxt;   // source level in the next fast cycle
        logic rise_nxt;  // next fast cycle is the first high cycle
        logic fall_nxt;  // next fast cycle is the first low cycle
    } src_t;

endpackage

// File: rtl/pcg_src_div.sv
// Divider producing the slow source and the double-rate source from one counter.
// Assumes HALF33 is even and at least 2. Both sources rise together at phase 0;
// reset parks the counter at the last phase so the first edge after reset is a rise.
module pcg_src_div
    import pcg_pkg::*;
#(
    parameter int HALF33 = 4
) (
    input  logic clk,
    input  logic rst_n,
    output src_t src33_o,
    output src_t src66_o
);
    localparam int PER33  = 2 * HALF33;
    localparam int PER66  = HALF33;
    localparam int HALF66 = HALF33 / 2;
    localparam int CW     = $clog2(PER33);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] ph66_nxt;
    logic          lvl33_q;
    logic          lvl66_q;

    // Next phase of the shared counter, wrapping at the slow period.
    always_comb begin
        cnt_nxt = (cnt_q == CW'(PER33 - 1)) ? '0 : cnt_q + 1'b1;
    end

    // Phase of the double-rate source, folded from the shared counter.
    always_comb begin
        ph66_nxt = (cnt_nxt >= CW'(PER66)) ? cnt_nxt - CW'(PER66) : cnt_nxt;
    end

    // Counter and current source levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= CW'(PER33 - 1);
            lvl33_q <= 1'b0;
            lvl66_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_nxt;
            lvl33_q <= (cnt_nxt < CW'(HALF33));
            lvl66_q <= (ph66_nxt < CW'(HALF66));
        end
    end

    // Pack the slow source bundle.
    always_comb begin
        src33_o.lvl_cur  = lvl33_q;
        src33_o.lvl_nxt  = (cnt_nxt < CW'(HALF33));
        src33_o.rise_nxt = (cnt_nxt == '0);
        src33_o.fall_nxt = (cnt_nxt == CW'(HALF33));
    end

    // Pack the double-rate source bundle.
    always_comb begin
        src66_o.lvl_cur  = lvl66_q;
        src66_o.lvl_nxt  = (ph66_nxt < CW'(HALF66));
        src66_o.rise_nxt = (ph66_nxt == '0);
        src66_o.fall_nxt = (ph66_nxt == CW'(HALF66));
    end

    // R7: every slow rising boundary is also a double-rate rising boundary.
    p_rate_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src33_o.rise_nxt |-> src66_o.rise_nxt);

endmodule

// File: rtl/pcg_sync2.sv
// Two-flop synchronizer for the asynchronous stop request.
// Resets to RST_VAL, the "not stopping" level, so outputs run after reset.
module pcg_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    // Capture and re-time the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/pcg_gate_cell.sv
// One glitch-free gated output. The run flag is loaded only at the source's
// rising boundary and cleared only at its falling boundary, and the output is
// a register of source level AND run flag. Pulses are therefore whole.
// Assumes the source bundle does not switch rate while out of reset.
module pcg_gate_cell
    import pcg_pkg::*;
#(
    parameter int PER_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  src_t src_i,
    input  logic want_i,
    output logic clk_o
);
    localparam int IW = $clog2(PER_MAX + 1);

    logic          run_q;
    logic          run_d;
    logic          out_q;
    logic [IW-1:0] idle_q;

    // Run flag changes only on a source phase boundary.
    always_comb begin
        run_d = run_q;
        if (src_i.rise_nxt) begin
            run_d = want_i;
        end else if (src_i.fall_nxt && !want_i) begin
            run_d = 1'b0;
        end
    end

    // Register the gated output and the run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            run_q <= run_d;
            out_q <= src_i.lvl_nxt & run_d;
        end
    end

    // Checker counter: consecutive cycles with the output not wanted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (want_i) begin
            idle_q <= '0;
        end else if (idle_q != IW'(PER_MAX)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign clk_o = out_q;

    // R4: the output rises only together with its source.
    p_rise_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> $rose(src_i.lvl_cur));

    // R3: the output falls only together with its source.
    p_fall_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q) |-> $fell(src_i.lvl_cur));

    // R10: the output is never high while the source is low.
    p_low_with_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !src_i.lvl_cur |-> !out_q);

    // R9: a full slow period without a run request leaves the output low.
    p_off_held_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q == IW'(PER_MAX)) |-> !out_q);

endmodule

// File: rtl/pclk_stop_gate.sv
// Top of the clock stop gate. One divider feeds NUM_PCLK gated outputs and one
// dedicated output. The synchronized stop request applies only to outputs at
// the slow rate that are not free-running.
// Assumes fast_sel_i is static outside reset.
module pclk_stop_gate
    import pcg_pkg::*;
#(
    parameter int NUM_PCLK = 8,
    parameter int HALF33   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_n_i,
    input  logic [NUM_PCLK-1:0] pclk_en_i,
    input  logic [NUM_PCLK-1:0] free_run_i,
    input  logic [NUM_PCLK-1:0] fast_sel_i,
    input  logic                fixed_en_i,
    output logic [NUM_PCLK-1:0] pclk_o,
    output logic                fixed_clk_o
);
    localparam int PER33 = 2 * HALF33;

    src_t src33;
    src_t src66;
    logic run_ok_n;

    pcg_src_div #(.HALF33(HALF33)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .src33_o (src33),
        .src66_o (src66)
    );

    pcg_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (stop_n_i),
        .q_o   (run_ok_n)
    );

    // Per-output rate select, stop exemption and gate.
    for (genvar g = 0; g < NUM_PCLK; g++) begin : g_out
        src_t src_g;
        logic want_g;
        assign src_g  = fast_sel_i[g] ? src66 : src33;
        assign want_g = pclk_en_i[g] & (run_ok_n | free_run_i[g] | fast_sel_i[g]);

        pcg_gate_cell #(.PER_MAX(PER33)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_g),
            .want_i (want_g),
            .clk_o  (pclk_o[g])
        );
    end

    // Dedicated output: enable only, never stopped.
    pcg_gate_cell #(.PER_MAX(PER33)) u_fixed (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src33),
        .want_i (fixed_en_i),
        .clk_o  (fixed_clk_o)
    );

endmodule

// File: tb/pclk_stop_gate_tb_top.sv
// Bench: directed corner cases plus seeded random toggling, compared each
// cycle against a requirement-level model and an independent pulse-width monitor.
module pclk_stop_gate_tb_top;
    localparam int N  = 8;
    localparam int H  = 4;
    localparam int P  = 2 * H;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_n = 1'b1;
    logic [N-1:0] en = '1;
    logic [N-1:0] fr = '0;
    logic [N-1:0] f66 = 8'hC0;
    logic         fen = 1'b1;
    logic [N-1:0] pclk;
    logic         fclk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    pclk_stop_gate #(.NUM_PCLK(N), .HALF33(H)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_n_i    (stop_n),
        .pclk_en_i   (en),
        .free_run_i  (fr),
        .fast_sel_i  (f66),
        .fixed_en_i  (fen),
        .pclk_o      (pclk),
        .fixed_clk_o (fclk)
    );

    // R2: source level for a phase index at a given rate.
    function automatic bit src_hi(int ph, bit fast);
        return fast ? ((ph % H) < (H / 2)) : (ph < H);
    endfunction

    // R2, R4: a run decision is taken where the source starts a high phase.
    function automatic bit src_bnd(int ph, bit fast);
        return fast ? ((ph % H) == 0) : (ph == 0);
    endfunction

    // Reference model built from R1..R10.
    int           m_ph;
    logic         m_s1, m_s2;
    logic [N-1:0] m_run, m_out;
    logic         m_frun, m_fout;

    always @(posedge clk) begin : model
        int           nph;
        logic [N-1:0] nrun, nout;
        logic         w, fr_run;
        if (!rst_n) begin
            m_ph <= P - 1; m_s1 <= 1'b1; m_s2 <= 1'b1;
            m_run <= '0; m_out <= '0; m_frun <= 1'b0; m_fout <= 1'b0;
        end else begin
            nph = (m_ph + 1) % P;
            for (int i = 0; i < N; i++) begin
                w = en[i] & (m_s2 | fr[i] | f66[i]);       // R5, R7, R8, R9
                nrun[i] = src_bnd(nph, f66[i]) ? w : m_run[i];
                nout[i] = src_hi(nph, f66[i]) & nrun[i];   // R10
            end
            fr_run = src_bnd(nph, 1'b0) ? fen : m_frun;     // R6
            m_ph <= nph; m_s1 <= stop_n; m_s2 <= m_s1;
            m_run <= nrun; m_out <= nout;
            m_frun <= fr_run; m_fout <= src_hi(nph, 1'b0) & fr_run;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        n_cmp++;
        if (pclk !== m_out) begin
            n_bad++;
            $display("FAIL %s: pclk_o=%b expected %b", tag, pclk, m_out);
        end
        n_cmp++;
        if (fclk !== m_fout) begin
            n_bad++;
            $display("FAIL %s (R6): fixed_clk_o=%b expected %b", tag, fclk, m_fout);
        end
    end

    // R3: independent high-pulse width monitor.
    int hc [N];
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) hc[i] = 0;
            else if (pclk[i]) hc[i]++;
            else if (hc[i] != 0) begin
                n_cmp++;
                if (hc[i] != (f66[i] ? H / 2 : H)) begin
                    n_bad++;
                    $display("FAIL R3: pulse width out %0d = %0d expected %0d",
                             i, hc[i], f66[i] ? H / 2 : H);
                end
                hc[i] = 0;
            end
        end
    end

    // Drive away from the active edge.
    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic direct_check(string t, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: value=%b expected %b", t, act, exp);
        end
    endtask

    task automatic random_run(int cycles);
        for (int c = 0; c < cycles; c++) begin
            if ($urandom_range(15) == 0) stop_n = ~stop_n;
            if ($urandom_range(31) == 0) en = N'($urandom);
            if ($urandom_range(31) == 0) fr = N'($urandom);
            if ($urandom_range(63) == 0) fen = ~fen;
            step(1);
        end
    endtask

    task automatic do_reset(logic [N-1:0] mask);
        rst_n = 1'b0; f66 = mask; stop_n = 1'b1; en = '1; fr = '0; fen = 1'b1;
        tag = "R1";
        step(4);
        direct_check("R1 reset outputs", {pclk[N-1:1], pclk[0] | fclk}, '0);
        rst_n = 1'b1;
    endtask

    logic saw_fixed, saw_fast;

    initial begin : wdog
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0330));
        step(1);
        do_reset(8'hC0);
        tag = "R2"; step(3 * P);
        tag = "R3"; step(P + 1); stop_n = 1'b0;       // stop mid-high
        step(4 * P);
        direct_check("R10 stopped slow outputs low", pclk & ~f66 & ~fr, '0);
        saw_fixed = 1'b0; saw_fast = 1'b0;
        for (int c = 0; c < P; c++) begin
            step(1);
            saw_fixed |= fclk;
            saw_fast  |= pclk[7];
        end
        direct_check("R6 fixed output runs during stop", {7'b0, saw_fixed}, 8'h01);
        direct_check("R7 fast output runs during stop", {7'b0, saw_fast}, 8'h01);
        tag = "R4"; step(H + 2); stop_n = 1'b1;        // release mid-low
        step(3 * P);
        tag = "R8"; fr = 8'h05; step(1); stop_n = 1'b0;
        step(4 * P); stop_n = 1'b1;
        tag = "R9"; step(3); en = 8'hF0; step(3 * P);
        direct_check("R9 disabled outputs low", pclk & 8'h0F, '0);
        en = '1; fen = 1'b0; step(3 * P);
        direct_check("R9 fixed output disabled", {7'b0, fclk}, '0);
        fen = 1'b1;
        tag = "R5"; random_run(3000);
        do_reset(8'h0F);
        tag = "R7"; random_run(3000);
        step(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule